// File: doc/BRIEF.md
# Partial-Fill Direct-Mapped Instruction Cache

This block sits between a processor's instruction fetch port and a word-addressed backing memory. It accepts one 32-bit fetch address at a time and returns one 32-bit instruction word. Cacheable fetches are looked up in a direct-mapped array of 256 lines, each line four words wide. Fetches at or above the uncached boundary skip the array and are read straight from memory.

A miss does not load the whole line. It reads memory one word at a time, starting at the requested word and ending at the last word of the line. The line then keeps the full fetch address as its tag. Because the words below the starting word were never loaded, a later fetch of one of those lower words is treated as a miss, even though its line address matches. The fill words collect in a small buffer and are written into the array in one step when the last read returns. A memory error therefore leaves the line as it was and returns a zero word. A reset or an invalidate pulse sets every tag and data word to all ones.

A three-state controller shares the single memory port between fills and uncached reads. The states are IDLE, FILL and RESP. In IDLE the block accepts a fetch and looks it up; a hit goes to RESP and a miss goes to FILL. The block stays in FILL while it issues one request per word and waits for each return, then goes to RESP once the last needed word has arrived or an error has been reported. RESP presents the word for one cycle and then returns to IDLE.

Top module: `pfill_icache`

## Requirements
- R1: After reset, fetch_ready is 1, fetch_rvalid is 0 and mem_req_valid is 0. Every tag and data word is all ones, so the first cacheable fetch to any line misses.
- R2: The line index is fetch address bits [11:4] and the word select is bits [3:2]. A hit raises fetch_rvalid in the cycle after acceptance with the stored word, and it issues no memory read.
- R3: A hit needs stored tag bits [31:4] equal to fetch bits [31:4], and the fetch address must not be lower than the stored fill address. A fetch of a lower word of a matching line misses.
- R4: A cacheable miss reads words addr[3:2] through 3 in ascending order, one request each, at byte addresses {addr[31:4], word, 2'b00}. The line tag then becomes the fetch address, and only those words are written.
- R5: A fetch at an address of 0xA0000000 or above makes exactly one memory read at the fetch address. It returns that data and leaves the array unchanged.
- R6: When memory reports mem_rerr with a read return, the fetch responds with the word 0 and the line keeps its previous tag and data.
- R7: A one-cycle pulse on inv_i sets every tag and data word to all ones, so lines that hit before the pulse miss after it.
- R8: fetch_ready is 0 from acceptance until the cycle after fetch_rvalid. fetch_rvalid lasts exactly one cycle, and mem_req_valid is never raised while fetch_ready is 1.
- R9: On a miss, fetch_data is the word that memory returned for the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | Invalidate-all pulse |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Block can accept a fetch (IDLE) |
| fetch_rvalid | output | 1 | Response word valid (RESP) |
| fetch_data | output | 32 | Instruction word returned |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data returned |
| mem_rdata | input | 32 | Memory read data |
| mem_rerr | input | 1 | Returned read hit an invalid address |

## Verification
A hit response is due exactly one cycle after acceptance, so the bench samples fetch_rvalid at the first falling edge after the accepting edge and requires it there. On a miss, each word takes a request cycle and a return cycle. The response therefore arrives after a number of cycles that depends on how many words are read, and the bench waits for fetch_rvalid in a bounded loop rather than at a fixed offset. While it waits, it checks that fetch_ready stays low. It then checks that fetch_rvalid has fallen one cycle later. The count of memory reads and their addresses are taken from a log that the bench memory model keeps, and each expected word is tagged with the stimulus step at which memory supplied it. This lets the bench tell a stale cached word from a freshly read one.

// File: rtl/pfill_icache_pkg.sv
package pfill_icache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/icache_hit_chk.sv
module icache_hit_chk #(
    parameter int          AW            = 32,
    parameter int          OFF_W         = 4,
    parameter logic [31:0] UNCACHED_BASE = 32'hA000_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] tag,
    output logic          cacheable,
    output logic          hit
);
    logic line_match;
    logic not_below;

    always_comb begin
        cacheable  = (addr < UNCACHED_BASE[AW-1:0]);
        line_match = (tag[AW-1:OFF_W] == addr[AW-1:OFF_W]);
        not_below  = (addr[OFF_W-1:0] >= tag[OFF_W-1:0]);
        hit        = cacheable && line_match && not_below;
    end
endmodule

// File: rtl/icache_array.sv
module icache_array #(
    parameter int LINES = 256,
    parameter int WORDS = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_i,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [AW-1:0]      rd_tag,
    output logic [WORDS*DW-1:0] rd_line,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [AW-1:0]      wr_tag,
    input  logic [WORDS-1:0]   wr_mask,
    input  logic [WORDS*DW-1:0] wr_line
);
    logic [AW-1:0] tag_q  [LINES];
    logic [DW-1:0] data_q [LINES][WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < LINES; l++) begin
                tag_q[l] <= '1;
                for (int w = 0; w < WORDS; w++) data_q[l][w] <= '1;
            end
        end else if (inv_i) begin
            for (int l = 0; l < LINES; l++) begin
                tag_q[l] <= '1;
                for (int w = 0; w < WORDS; w++) data_q[l][w] <= '1;
            end
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            for (int w = 0; w < WORDS; w++)
                if (wr_mask[w]) data_q[wr_idx][w] <= wr_line[w*DW +: DW];
        end
    end

    always_comb begin
        rd_tag = tag_q[rd_idx];
        for (int w = 0; w < WORDS; w++) rd_line[w*DW +: DW] = data_q[rd_idx][w];
    end

    // R7: an invalidate pulse leaves the first and last lines all ones
    p_inv_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_i |=> (tag_q[0] == '1 && tag_q[LINES-1] == '1 && data_q[0][0] == '1));
endmodule

// File: rtl/pfill_icache.sv
module pfill_icache
    import pfill_icache_pkg::*;
#(
    parameter int          LINES         = 256,
    parameter int          WORDS         = 4,
    parameter int          AW            = 32,
    parameter int          DW            = 32,
    parameter logic [31:0] UNCACHED_BASE = 32'hA000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inv_i,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_ready,
    output logic          fetch_rvalid,
    output logic [DW-1:0] fetch_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rerr
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + 2;
    localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WORDS - 1);

    ctl_state_t state_q, state_d;

    logic [AW-1:0]     addr_q;
    logic              cached_q;
    logic [WSEL_W-1:0] ptr_q;
    logic              pend_q;
    logic [DW-1:0]     resp_q;
    logic [DW-1:0]     buf_q [WORDS];

    logic [IDX_W-1:0]      rd_idx;
    logic [AW-1:0]         rd_tag;
    logic [WORDS*DW-1:0]   rd_line;
    logic                  lookup_hit;
    logic                  lookup_cacheable;
    logic [WSEL_W-1:0]     req_word;
    logic                  ret_ok;
    logic                  fill_last;
    logic                  wr_en;
    logic [WORDS-1:0]      wr_mask;
    logic [WORDS*DW-1:0]   wr_line;

    assign rd_idx    = fetch_addr[OFF_W +: IDX_W];
    assign req_word  = addr_q[OFF_W-1:2];
    assign ret_ok    = (state_q == ST_FILL) && pend_q && mem_rvalid && !mem_rerr;
    assign fill_last = (ptr_q == LAST_W);

    icache_hit_chk #(
        .AW(AW), .OFF_W(OFF_W), .UNCACHED_BASE(UNCACHED_BASE)
    ) u_hit (
        .addr(fetch_addr), .tag(rd_tag),
        .cacheable(lookup_cacheable), .hit(lookup_hit)
    );

    icache_array #(
        .LINES(LINES), .WORDS(WORDS), .AW(AW), .DW(DW)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .inv_i(inv_i),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_line(rd_line),
        .wr_en(wr_en), .wr_idx(addr_q[OFF_W +: IDX_W]), .wr_tag(addr_q),
        .wr_mask(wr_mask), .wr_line(wr_line)
    );

    // line commit: only at the final return of a cached fill without error
    always_comb begin
        wr_en = ret_ok && cached_q && fill_last;
        for (int w = 0; w < WORDS; w++) begin
            wr_mask[w] = (WSEL_W'(w) >= req_word);
            wr_line[w*DW +: DW] = (WSEL_W'(w) == ptr_q) ? mem_rdata : buf_q[w];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fetch_valid) state_d = lookup_hit ? ST_RESP : ST_FILL;
            ST_FILL: if (pend_q && mem_rvalid && (mem_rerr || !cached_q || fill_last))
                         state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cached_q <= 1'b0;
            ptr_q    <= '0;
            pend_q   <= 1'b0;
            resp_q   <= '0;
            for (int w = 0; w < WORDS; w++) buf_q[w] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (fetch_valid) begin
                    addr_q   <= fetch_addr;
                    cached_q <= lookup_cacheable;
                    ptr_q    <= fetch_addr[OFF_W-1:2];
                    pend_q   <= 1'b0;
                    if (lookup_hit) resp_q <= rd_line[fetch_addr[OFF_W-1:2]*DW +: DW];
                end
                ST_FILL: begin
                    if (!pend_q && mem_req_ready) pend_q <= 1'b1;
                    if (pend_q && mem_rvalid) begin
                        pend_q <= 1'b0;
                        if (mem_rerr) begin
                            resp_q <= '0;
                        end else begin
                            buf_q[ptr_q] <= mem_rdata;
                            if (ptr_q == req_word) resp_q <= mem_rdata;
                            if (cached_q && !fill_last) ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fetch_ready   = (state_q == ST_IDLE);
        fetch_rvalid  = (state_q == ST_RESP);
        fetch_data    = resp_q;
        mem_req_valid = (state_q == ST_FILL) && !pend_q;
        mem_addr      = cached_q ? {addr_q[AW-1:OFF_W], ptr_q, 2'b00} : addr_q;
    end

    // R2: an accepted hit answers on the next cycle without a memory request
    p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready && lookup_hit) |=> (fetch_rvalid && !mem_req_valid));

    // R6: an erroring return yields a zero word on the next cycle
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && pend_q && mem_rvalid && mem_rerr) |=> (fetch_rvalid && fetch_data == '0));

    // R8: the response is a single-cycle pulse followed by readiness
    p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rvalid |=> (!fetch_rvalid && fetch_ready));

    // R8: no memory request while ready for a new fetch
    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !fetch_ready);

    // R4: consecutive fill requests for a cached line stay inside that line
    p_fill_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && $past(mem_req_valid) == 1'b0 && state_q == ST_FILL && cached_q)
        |-> (mem_addr[AW-1:OFF_W] == addr_q[AW-1:OFF_W]));
endmodule

// File: tb/pfill_icache_tb_top.sv
`timescale 1ns/1ps
module pfill_icache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_i = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, fetch_rvalid;
    logic [31:0] fetch_data;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;

    always #2 clk = ~clk;

    pfill_icache dut_i (
        .clk(clk), .rst_n(rst_n), .inv_i(inv_i),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_rvalid(fetch_rvalid), .fetch_data(fetch_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;
    logic [7:0]  gen     = '0;
    bit          err_en  = 1'b0;
    int          rd_cnt  = 0;
    logic [31:0] rd_log [64];

    function automatic logic [31:0] memword(input logic [31:0] a, input logic [7:0] g);
        return (a ^ 32'hC0DE_0000) + {24'd0, g};
    endfunction

    // backing memory: answers one cycle after each accepted request
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) begin
            mem_rvalid      <= 1'b1;
            mem_rdata       <= err_en ? 32'hDEAD_BEEF : memword(mem_addr, gen);
            mem_rerr        <= err_en;
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt          <= rd_cnt + 1;
        end else begin
            mem_rvalid <= 1'b0;
            mem_rerr   <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, output logic [31:0] data,
                            output int reads, output int lat, output int first_rd);
        bit busy_ok;
        @(negedge clk);
        while (!fetch_ready) @(negedge clk);
        first_rd    = rd_cnt;
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!fetch_rvalid && lat < 200) begin
            if (fetch_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        data = fetch_data;
        chk(busy_ok, "R8 ready low while busy", {31'd0, busy_ok}, 32'd1);
        @(negedge clk);
        chk(!fetch_rvalid && fetch_ready, "R8 single-cycle response",
            {30'd0, fetch_rvalid, fetch_ready}, 32'd1);
        reads = rd_cnt - first_rd;
    endtask

    // stimulus table: {addr[43:12], expected reads[11:8], step whose memory data is expected[7:0]}
    localparam int NV = 16;
    localparam logic [43:0] VEC [NV] = '{
        {32'h0000_1008, 4'd2, 8'd0},
        {32'h0000_100C, 4'd0, 8'd0},
        {32'h0000_1004, 4'd3, 8'd2},
        {32'h0000_1008, 4'd0, 8'd2},
        {32'h0000_1000, 4'd4, 8'd4},
        {32'h0000_1000, 4'd0, 8'd4},
        {32'h0000_2000, 4'd4, 8'd6},
        {32'h0000_1004, 4'd3, 8'd7},
        {32'hA000_1004, 4'd1, 8'd8},
        {32'h0000_1004, 4'd0, 8'd7},
        {32'hBFC0_0000, 4'd1, 8'd10},
        {32'h0000_0FFC, 4'd1, 8'd11},
        {32'h0000_0FFC, 4'd0, 8'd11},
        {32'h9FFF_FFF0, 4'd4, 8'd13},
        {32'h0000_0FFC, 4'd1, 8'd14},
        {32'h0000_0FF8, 4'd2, 8'd15}
    };

    initial begin
        logic [31:0] d;
        int rd, lat, f0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fetch_ready && !fetch_rvalid && !mem_req_valid, "R1 reset outputs",
            {29'd0, fetch_ready, fetch_rvalid, mem_req_valid}, 32'd4);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] a;
            int          er;
            logic [7:0]  eg;
            a  = VEC[i][43:12];
            er = int'(VEC[i][11:8]);
            eg = VEC[i][7:0];
            gen = 8'(i);
            do_fetch(a, d, rd, lat, f0);
            // R9 / R2: returned word, fresh on miss and stale on hit
            chk(d == memword(a, eg), (er == 0) ? "R2 hit data" : "R9 miss data", d, memword(a, eg));
            // R3 / R4 / R5: read count decides hit or miss
            chk(rd == er, (a >= 32'hA000_0000) ? "R5 uncached one read" :
                          ((er == 0) ? "R3 hit no read" : "R3 R4 partial fill reads"),
                32'(rd), 32'(er));
            if (er == 0) chk(lat == 1, "R2 hit latency", 32'(lat), 32'd1);
            if (er > 0) begin
                bit ord_ok;
                ord_ok = 1'b1;
                for (int k = 0; k < er; k++) begin
                    logic [31:0] ea;
                    ea = (a >= 32'hA000_0000) ? a : {a[31:4], a[3:2] + 2'(k), 2'b00};
                    if (rd_log[(f0 + k) % 64] != ea) ord_ok = 1'b0;
                end
                chk(ord_ok, "R4 fill address order", rd_log[f0 % 64], a);
            end
        end

        // R6: memory error returns zero and leaves the line unchanged
        gen = 8'd100;
        do_fetch(32'h0000_3010, d, rd, lat, f0);
        chk(rd == 4, "R6 setup fill", 32'(rd), 32'd4);
        err_en = 1'b1;
        do_fetch(32'h0000_4010, d, rd, lat, f0);
        chk(d == 32'd0, "R6 error data zero", d, 32'd0);
        err_en = 1'b0;
        gen = 8'd101;
        do_fetch(32'h0000_3018, d, rd, lat, f0);
        chk(rd == 0 && d == memword(32'h0000_3018, 8'd100), "R6 line kept", d,
            memword(32'h0000_3018, 8'd100));

        // R7: invalidate pulse forces a miss
        @(negedge clk);
        inv_i = 1'b1;
        @(negedge clk);
        inv_i = 1'b0;
        gen = 8'd102;
        do_fetch(32'h0000_3010, d, rd, lat, f0);
        chk(rd == 4 && d == memword(32'h0000_3010, 8'd102), "R7 miss after invalidate",
            32'(rd), 32'd4);

        // R1: reset in mid-run also clears the array
        do_fetch(32'h0000_3014, d, rd, lat, f0);
        chk(rd == 0, "R1 hit before reset", 32'(rd), 32'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(fetch_ready && !fetch_rvalid && !mem_req_valid, "R1 outputs in reset",
            {29'd0, fetch_ready, fetch_rvalid, mem_req_valid}, 32'd4);
        rst_n = 1'b1;
        gen = 8'd103;
        do_fetch(32'h0000_3014, d, rd, lat, f0);
        chk(rd == 3 && d == memword(32'h0000_3014, 8'd103), "R1 miss after reset", 32'(rd), 32'd3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule